// File: doc/BRIEF.md
# I2C Master SCL Timing Generator

This block paces the clock line of an I2C master. A byte sequencer above it asks for a START, for more bit clocks, or for a STOP. The block then drives SCL low and releases it for lengths taken from three timing register words. Inside each phase it raises a one-cycle strobe at a set position. One strobe sits in the high phase and marks when SDA is to be sampled. The other sits in the low phase and marks when the sequencer may change SDA. It also raises strobes at the points where SDA has to fall for a START and rise for a STOP.

Each low and high phase is lengthened by a fixed number of reference clocks. The high phase only begins once SCL reads back high, so a slave that holds SCL low stretches the low time without shortening the high time. A lead-in wait comes before every START. After every STOP there is a bus-free wait, and a START request is not taken while it runs. Each phase takes its length and strobe position from the registers at the moment it starts.

Top module: `i2c_scl_timer`

## Requirements
- R1: While reset is asserted and in the first cycle after it, SCL is released (scl_pull = 0) and every strobe and done output is 0.
- R2: A low phase holds scl_pull = 1 for exactly lo_reg[31:16] + 18 cycles, and lo_done is 1 in its last cycle.
- R3: An unstretched high phase keeps SCL released for lo..: one readback cycle plus hi_reg[31:16] + 19 counting cycles, and hi_done is 1 in the last of them, after which SCL is pulled low.
- R4: With no stretching, one bit period (low plus high) lasts hi_reg[31:16] + lo_reg[31:16] + 38 cycles. When the low count equals the high count minus 6, this is 2 × (high count − 3) + 38.
- R5: tx_stb pulses once in a low phase, in the cycle at index lo_reg[15:0] counted from 0 at the first pulled cycle. If that index is not inside the phase, it does not pulse.
- R6: smp_stb pulses once in a high phase, in the cycle at index hi_reg[15:0] of the counting part of the phase. If that index is not inside the phase, it does not pulse.
- R7: The high-phase count starts only in the cycle after scl_in is seen high while SCL is released. A slave holding SCL low for S cycles makes the released time S + hi_reg[31:16] + 19 and moves smp_stb by the same amount.
- R8: A req_start while idle starts a lead-in of gap_reg[15:0] cycles (0 counts as 1), with sda_fall_stb in its last cycle. SCL then stays released for hi_reg[31:16] + 19 more cycles before the first low phase.
- R9: req_stop is sampled at the end of a low phase. SCL is then released, and once it reads high it stays high for hi_reg[31:16] + 19 cycles, with sda_rise_stb in the last of them.
- R10: After sda_rise_stb a bus-free wait of gap_reg[31:16] cycles (0 counts as 1) follows, during which req_start is ignored. A req_start held high from the STOP gives sda_fall_stb exactly bus-free + 1 + lead-in cycles after sda_rise_stb.
- R11: If neither req_run nor req_stop is high at the end of a low phase, SCL stays pulled low until one of them rises. A req_run then releases SCL in the next cycle.
- R12: A register write takes effect at the next phase boundary: a phase already running keeps the length it started with.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| hi_reg | input | 32 | [31:16] high-phase count, [15:0] sample position |
| lo_reg | input | 32 | [31:16] low-phase count, [15:0] transmit position |
| gap_reg | input | 32 | [31:16] bus-free count, [15:0] lead-in count |
| req_start | input | 1 | Request a START condition (taken only when idle) |
| req_run | input | 1 | Keep producing bit clocks |
| req_stop | input | 1 | Request a STOP condition at the end of the low phase |
| scl_in | input | 1 | SCL readback from the bus |
| scl_pull | output | 1 | 1 drives SCL low, 0 releases it |
| smp_stb | output | 1 | Single-cycle SDA sample strobe in the high phase |
| tx_stb | output | 1 | Single-cycle SDA change strobe in the low phase |
| hi_done | output | 1 | Last cycle of a data high phase |
| lo_done | output | 1 | Last cycle of a low phase |
| sda_fall_stb | output | 1 | SDA falls now to form a START |
| sda_rise_stb | output | 1 | SDA rises now to form a STOP |

## Verification
The bench drives strobe positions that land on the first and the last cycle of a phase, and positions past the end of a phase. A counter off by one would move or drop a strobe, and a missing range check would fire one that should be absent. A slave stretch of several cycles catches a design that starts the high count as soon as SCL is released, because that design would shorten the high time. A START held through the bus-free wait exposes a design that accepts it early. A low-count write in the middle of a phase catches a live reload, which would change the length of the current phase. Zero lead-in and a low phase with no run request show whether the design hangs or releases SCL when it should not.

// File: rtl/i2c_tgen_pkg.sv
`timescale 1ns/1ps
package i2c_tgen_pkg;

    localparam int TG_CNT_W = 16;
    localparam int TG_PH_W  = TG_CNT_W + 1;
    localparam int TG_REG_W = 2 * TG_CNT_W;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_LEADIN,
        ST_START_HOLD,
        ST_LOW,
        ST_PARK,
        ST_HIGH_WAIT,
        ST_HIGH,
        ST_STOP_WAIT,
        ST_STOP_HOLD,
        ST_BUSFREE
    } tg_state_e;

    typedef struct packed {
        logic [TG_CNT_W-1:0] hi_len;
        logic [TG_CNT_W-1:0] smp_at;
        logic [TG_CNT_W-1:0] lo_len;
        logic [TG_CNT_W-1:0] tx_at;
        logic [TG_CNT_W-1:0] bus_free;
        logic [TG_CNT_W-1:0] lead_in;
    } tg_cfg_t;

    // A wait count of zero still takes one cycle.
    function automatic logic [TG_PH_W-1:0] tg_min_one(input logic [TG_CNT_W-1:0] v);
        return (v == '0) ? TG_PH_W'(1) : {1'b0, v};
    endfunction

    // Phase length = programmed count + fixed engine overhead.
    function automatic logic [TG_PH_W-1:0] tg_extend(input logic [TG_CNT_W-1:0] v,
                                                     input int extra);
        return {1'b0, v} + TG_PH_W'(extra);
    endfunction

endpackage

// File: rtl/i2c_tgen_decode.sv
`timescale 1ns/1ps
module i2c_tgen_decode
    import i2c_tgen_pkg::*;
#(
    parameter int HI_EXTRA = 19,
    parameter int LO_EXTRA = 18
) (
    input  tg_cfg_t              cfg,
    input  tg_state_e            st_next,
    output logic [TG_PH_W-1:0]   ph_len,
    output logic [TG_PH_W-1:0]   ph_mark
);

    always_comb begin
        ph_len  = TG_PH_W'(1);
        ph_mark = '1;
        case (st_next)
            ST_LEADIN:     ph_len = tg_min_one(cfg.lead_in);
            ST_START_HOLD: ph_len = tg_extend(cfg.hi_len, HI_EXTRA);
            ST_STOP_HOLD:  ph_len = tg_extend(cfg.hi_len, HI_EXTRA);
            ST_HIGH: begin
                ph_len  = tg_extend(cfg.hi_len, HI_EXTRA);
                ph_mark = {1'b0, cfg.smp_at};
            end
            ST_LOW: begin
                ph_len  = tg_extend(cfg.lo_len, LO_EXTRA);
                ph_mark = {1'b0, cfg.tx_at};
            end
            ST_BUSFREE:    ph_len = tg_min_one(cfg.bus_free);
            default: begin
                ph_len  = TG_PH_W'(1);
                ph_mark = '1;
            end
        endcase
    end

endmodule

// File: rtl/i2c_tgen_counter.sv
`timescale 1ns/1ps
module i2c_tgen_counter #(
    parameter int W = 17
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] len_in,
    input  logic [W-1:0] mark_in,
    output logic         at_end,
    output logic         at_mark
);

    logic [W-1:0] cnt;
    logic [W-1:0] len_q;
    logic [W-1:0] mark_q;

    assign at_end  = (cnt == len_q - W'(1));
    assign at_mark = (cnt == mark_q);

    // Length and mark are captured only at a phase boundary.
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            len_q  <= W'(1);
            mark_q <= '1;
        end else if (load) begin
            cnt    <= '0;
            len_q  <= len_in;
            mark_q <= mark_in;
        end else if (!at_end) begin
            cnt    <= cnt + W'(1);
        end
    end

endmodule

// File: rtl/i2c_tgen_fsm.sv
`timescale 1ns/1ps
module i2c_tgen_fsm
    import i2c_tgen_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      req_start,
    input  logic      req_run,
    input  logic      req_stop,
    input  logic      scl_in,
    input  logic      at_end,
    input  logic      at_mark,
    output tg_state_e st_next,
    output logic      load,
    output logic      scl_pull,
    output logic      smp_stb,
    output logic      tx_stb,
    output logic      hi_done,
    output logic      lo_done,
    output logic      sda_fall_stb,
    output logic      sda_rise_stb
);

    tg_state_e st;

    always_comb begin
        st_next = st;
        case (st)
            ST_IDLE:       if (req_start) st_next = ST_LEADIN;
            ST_LEADIN:     if (at_end)    st_next = ST_START_HOLD;
            ST_START_HOLD: if (at_end)    st_next = ST_LOW;
            ST_LOW: begin
                if (at_end) begin
                    if (req_stop)     st_next = ST_STOP_WAIT;
                    else if (req_run) st_next = ST_HIGH_WAIT;
                    else              st_next = ST_PARK;
                end
            end
            ST_PARK: begin
                if (req_stop)         st_next = ST_STOP_WAIT;
                else if (req_run)     st_next = ST_HIGH_WAIT;
            end
            ST_HIGH_WAIT:  if (scl_in)    st_next = ST_HIGH;
            ST_HIGH:       if (at_end)    st_next = ST_LOW;
            ST_STOP_WAIT:  if (scl_in)    st_next = ST_STOP_HOLD;
            ST_STOP_HOLD:  if (at_end)    st_next = ST_BUSFREE;
            ST_BUSFREE:    if (at_end)    st_next = ST_IDLE;
            default:                      st_next = ST_IDLE;
        endcase
    end

    assign load = (st_next != st);

    always_ff @(posedge clk) begin
        if (rst) st <= ST_IDLE;
        else     st <= st_next;
    end

    assign scl_pull     = (st == ST_LOW) || (st == ST_PARK);
    assign smp_stb      = (st == ST_HIGH) && at_mark;
    assign tx_stb       = (st == ST_LOW) && at_mark;
    assign hi_done      = (st == ST_HIGH) && at_end;
    assign lo_done      = (st == ST_LOW) && at_end;
    assign sda_fall_stb = (st == ST_LEADIN) && at_end;
    assign sda_rise_stb = (st == ST_STOP_HOLD) && at_end;

endmodule

// File: rtl/i2c_scl_timer.sv
`timescale 1ns/1ps
module i2c_scl_timer
    import i2c_tgen_pkg::*;
#(
    parameter int HI_EXTRA = 19,
    parameter int LO_EXTRA = 18
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [TG_REG_W-1:0] hi_reg,
    input  logic [TG_REG_W-1:0] lo_reg,
    input  logic [TG_REG_W-1:0] gap_reg,
    input  logic                req_start,
    input  logic                req_run,
    input  logic                req_stop,
    input  logic                scl_in,
    output logic                scl_pull,
    output logic                smp_stb,
    output logic                tx_stb,
    output logic                hi_done,
    output logic                lo_done,
    output logic                sda_fall_stb,
    output logic                sda_rise_stb
);

    tg_cfg_t              cfg;
    tg_state_e            st_next;
    logic                 load;
    logic                 at_end;
    logic                 at_mark;
    logic [TG_PH_W-1:0]   ph_len;
    logic [TG_PH_W-1:0]   ph_mark;

    // Upper half of each word is a phase length, lower half a position or wait.
    assign cfg.hi_len   = hi_reg[TG_REG_W-1:TG_CNT_W];
    assign cfg.smp_at   = hi_reg[TG_CNT_W-1:0];
    assign cfg.lo_len   = lo_reg[TG_REG_W-1:TG_CNT_W];
    assign cfg.tx_at    = lo_reg[TG_CNT_W-1:0];
    assign cfg.bus_free = gap_reg[TG_REG_W-1:TG_CNT_W];
    assign cfg.lead_in  = gap_reg[TG_CNT_W-1:0];

    i2c_tgen_decode #(
        .HI_EXTRA (HI_EXTRA),
        .LO_EXTRA (LO_EXTRA)
    ) u_decode (
        .cfg     (cfg),
        .st_next (st_next),
        .ph_len  (ph_len),
        .ph_mark (ph_mark)
    );

    i2c_tgen_counter #(
        .W (TG_PH_W)
    ) u_counter (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .len_in  (ph_len),
        .mark_in (ph_mark),
        .at_end  (at_end),
        .at_mark (at_mark)
    );

    i2c_tgen_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .req_start    (req_start),
        .req_run      (req_run),
        .req_stop     (req_stop),
        .scl_in       (scl_in),
        .at_end       (at_end),
        .at_mark      (at_mark),
        .st_next      (st_next),
        .load         (load),
        .scl_pull     (scl_pull),
        .smp_stb      (smp_stb),
        .tx_stb       (tx_stb),
        .hi_done      (hi_done),
        .lo_done      (lo_done),
        .sda_fall_stb (sda_fall_stb),
        .sda_rise_stb (sda_rise_stb)
    );

endmodule

// File: rtl/i2c_scl_timer_chk.sv
`timescale 1ns/1ps
module i2c_scl_timer_chk #(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          scl_in,
    input logic          scl_pull,
    input logic          smp_stb,
    input logic          tx_stb,
    input logic          hi_done,
    input logic          lo_done,
    input logic          sda_fall_stb,
    input logic          sda_rise_stb,
    input logic [CW-1:0] bf_cfg
);

    localparam int GW = CW + 2;

    // Cycles since the last STOP edge, saturating; starts saturated.
    logic [GW-1:0] bf_gap;
    always_ff @(posedge clk) begin
        if (rst)                bf_gap <= '1;
        else if (sda_rise_stb)  bf_gap <= '0;
        else if (bf_gap != '1)  bf_gap <= bf_gap + GW'(1);
    end

    a_r5_tx_in_low: assert property (@(posedge clk) disable iff (rst)
        tx_stb |-> scl_pull);
    a_r5_tx_single: assert property (@(posedge clk) disable iff (rst)
        tx_stb |=> !tx_stb);
    a_r6_smp_released: assert property (@(posedge clk) disable iff (rst)
        smp_stb |-> (!scl_pull && scl_in));
    a_r6_smp_single: assert property (@(posedge clk) disable iff (rst)
        smp_stb |=> !smp_stb);
    a_r2_lo_done_pulled: assert property (@(posedge clk) disable iff (rst)
        lo_done |-> scl_pull);
    a_r3_hi_done_then_low: assert property (@(posedge clk) disable iff (rst)
        hi_done |=> scl_pull);
    a_r8_fall_released: assert property (@(posedge clk) disable iff (rst)
        sda_fall_stb |-> !scl_pull);
    a_r9_rise_released: assert property (@(posedge clk) disable iff (rst)
        sda_rise_stb |-> !scl_pull);
    a_r10_bus_free: assert property (@(posedge clk) disable iff (rst)
        sda_fall_stb |-> (bf_gap > {2'b00, bf_cfg}));

endmodule

bind i2c_scl_timer i2c_scl_timer_chk #(.CW(16)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .scl_in       (scl_in),
    .scl_pull     (scl_pull),
    .smp_stb      (smp_stb),
    .tx_stb       (tx_stb),
    .hi_done      (hi_done),
    .lo_done      (lo_done),
    .sda_fall_stb (sda_fall_stb),
    .sda_rise_stb (sda_rise_stb),
    .bf_cfg       (gap_reg[31:16])
);

// File: tb/i2c_scl_timer_tb.sv
`timescale 1ns/1ps
module i2c_scl_timer_tb;

    localparam int HI_X = 19;
    localparam int LO_X = 18;
    localparam int NVEC = 5;

    typedef struct packed {
        logic [15:0] hi;
        logic [15:0] smp;
        logic [15:0] lo;
        logic [15:0] tx;
    } vec_t;

    // high count, sample position, low count, transmit position
    localparam vec_t VECS [NVEC] = '{
        '{16'd10, 16'd5,  16'd4,  16'd1 },
        '{16'd0,  16'd0,  16'd0,  16'd0 },
        '{16'd20, 16'd29, 16'd14, 16'd20},
        '{16'd3,  16'd40, 16'd2,  16'd25},
        '{16'd12, 16'd30, 16'd6,  16'd23}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] hi_reg = '0;
    logic [31:0] lo_reg = '0;
    logic [31:0] gap_reg = '0;
    logic        req_start = 1'b0;
    logic        req_run = 1'b0;
    logic        req_stop = 1'b0;
    logic        stretch = 1'b0;
    logic        scl_in;
    logic        scl_pull, smp_stb, tx_stb, hi_done, lo_done;
    logic        sda_fall_stb, sda_rise_stb;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    // Open-drain bus: low if the master pulls or a slave stretches.
    assign scl_in = !scl_pull && !stretch;

    i2c_scl_timer u_dut (
        .clk (clk), .rst (rst),
        .hi_reg (hi_reg), .lo_reg (lo_reg), .gap_reg (gap_reg),
        .req_start (req_start), .req_run (req_run), .req_stop (req_stop),
        .scl_in (scl_in), .scl_pull (scl_pull),
        .smp_stb (smp_stb), .tx_stb (tx_stb),
        .hi_done (hi_done), .lo_done (lo_done),
        .sda_fall_stb (sda_fall_stb), .sda_rise_stb (sda_rise_stb)
    );

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // From idle: pulse req_start; return fall index and first pulled index.
    task automatic do_start(output int fall, output int pull);
        int idx;
        req_start = 1'b1;
        @(negedge clk);
        req_start = 1'b0;
        idx = 0;
        fall = -1;
        while (!scl_pull) begin
            if (sda_fall_stb) fall = idx;
            idx++;
            @(negedge clk);
        end
        pull = idx;
    endtask

    // Entered at the first pulled cycle; leaves at the first released one.
    task automatic run_low(output int len, output int txp, output int ntx);
        len = 0; txp = -1; ntx = 0;
        while (scl_pull) begin
            if (tx_stb) begin ntx++; txp = len; end
            len++;
            @(negedge clk);
        end
    endtask

    // Entered at the first released cycle; s = cycles the slave holds SCL low (>=1).
    task automatic run_high(input int s, output int len, output int smpp, output int nsmp);
        len = 0; smpp = -1; nsmp = 0;
        while (!scl_pull) begin
            if (smp_stb) begin nsmp++; smpp = len; end
            len++;
            stretch = (len < s);
            @(negedge clk);
        end
        stretch = 1'b0;
    endtask

    task automatic wait_rise(output int idx);
        idx = 0;
        while (!sda_rise_stb) begin
            idx++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog (all requirements): actual hung expected finished");
        report();
    end

    initial begin
        int fall, pull, len, pos, n, idx, low1, high1;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 outputs in reset", int'({scl_pull, smp_stb, tx_stb, hi_done,
            lo_done, sda_fall_stb, sda_rise_stb}), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 outputs after reset", int'({scl_pull, smp_stb, tx_stb, hi_done,
            lo_done, sda_fall_stb, sda_rise_stb}), 0);

        // Table walk: R2 R3 R4 R5 R6 R8 R9
        gap_reg = {16'd3, 16'd2};
        for (int v = 0; v < NVEC; v++) begin
            int hi, smp, lo, tx;
            hi = int'(VECS[v].hi); smp = int'(VECS[v].smp);
            lo = int'(VECS[v].lo); tx = int'(VECS[v].tx);
            hi_reg = {VECS[v].hi, VECS[v].smp};
            lo_reg = {VECS[v].lo, VECS[v].tx};
            req_run = 1'b1;
            do_start(fall, pull);
            chk("R8 lead-in fall index", fall, 1);
            chk("R8 first pull index", pull, 2 + hi + HI_X);
            run_low(low1, pos, n);
            chk("R2 low length", low1, lo + LO_X);
            chk("R5 tx pulse count", n, (tx < lo + LO_X) ? 1 : 0);
            if (tx < lo + LO_X) chk("R5 tx position", pos, tx);
            run_high(1, high1, pos, n);
            chk("R3 released length", high1, 1 + hi + HI_X);
            chk("R6 sample pulse count", n, (smp < hi + HI_X) ? 1 : 0);
            if (smp < hi + HI_X) chk("R6 sample position", pos, 1 + smp);
            chk("R4 bit period", low1 + high1, hi + lo + 38);
            req_run = 1'b0;
            req_stop = 1'b1;
            run_low(len, pos, n);
            chk("R2 second low length", len, lo + LO_X);
            wait_rise(idx);
            chk("R9 stop rise index", idx, hi + HI_X);
            req_stop = 1'b0;
            repeat (6) @(negedge clk);
        end

        // R7: slave stretches SCL for 7 cycles
        hi_reg = {16'd10, 16'd4};
        lo_reg = {16'd5, 16'd2};
        req_run = 1'b1;
        do_start(fall, pull);
        run_low(len, pos, n);
        run_high(7, len, pos, n);
        chk("R7 stretched released length", len, 7 + 10 + HI_X);
        chk("R7 sample shifted by stretch", pos, 7 + 4);
        req_run = 1'b0; req_stop = 1'b1;
        run_low(len, pos, n);
        wait_rise(idx);
        req_stop = 1'b0;
        repeat (6) @(negedge clk);

        // R8: zero lead-in behaves as one cycle
        gap_reg = {16'd3, 16'd0};
        hi_reg = {16'd4, 16'd1};
        req_run = 1'b1;
        do_start(fall, pull);
        chk("R8 zero lead-in fall index", fall, 0);
        chk("R8 zero lead-in pull index", pull, 1 + 4 + HI_X);

        // R12: mid-phase low-count change applies to the next low phase
        lo_reg = {16'd4, 16'd0};
        run_low(len, pos, n);
        run_high(1, len, pos, n);
        len = 0;
        while (scl_pull) begin
            if (len == 2) lo_reg = {16'd9, 16'd0};
            len++;
            @(negedge clk);
        end
        chk("R12 running phase keeps old length", len, 4 + LO_X);
        run_high(1, len, pos, n);
        run_low(len, pos, n);
        chk("R12 next phase uses new length", len, 9 + LO_X);

        // R11: no run request parks SCL low
        req_run = 1'b0;
        run_high(1, len, pos, n);
        repeat (9 + LO_X + 40) @(negedge clk);
        chk("R11 SCL held low while parked", int'(scl_pull), 1);
        req_run = 1'b1;
        @(negedge clk);
        chk("R11 run releases SCL next cycle", int'(scl_pull), 0);
        run_high(1, len, pos, n);

        // R10: START held through the bus-free wait
        gap_reg = {16'd10, 16'd3};
        req_run = 1'b0; req_stop = 1'b1;
        run_low(len, pos, n);
        wait_rise(idx);
        req_stop = 1'b0;
        req_start = 1'b1;
        idx = 0;
        while (!sda_fall_stb && idx < 1000) begin
            idx++;
            @(negedge clk);
        end
        req_start = 1'b0;
        chk("R10 start delayed by bus-free", idx, 10 + 1 + 3);
        while (!scl_pull) @(negedge clk);
        req_stop = 1'b1;
        run_low(len, pos, n);
        wait_rise(idx);
        req_stop = 1'b0;
        repeat (15) @(negedge clk);

        report();
    end

endmodule